// File: doc/BRIEF.md
# Float and Fixed-Point Integer Converter

This block converts a single 32-bit operand in either direction between the IEEE-754 single-precision format and a 32-bit integer. One control input picks the direction. A second control input says whether the integer side is two's complement or unsigned. A programmable binary-point position treats the integer as a fixed-point number that has `fpos_i` fraction bits. Converting to integer therefore multiplies the float by 2^fpos_i, and converting to float divides the integer by 2^fpos_i.

A host raises `start_i` for one cycle with the operand and controls applied. The block returns the result together with two status bits one cycle later, with `valid_o` high for that cycle. The result and the status bits then stay unchanged until the next start. Float-to-integer conversion truncates toward zero. It saturates values out of range and reports them, and it reports separately any nonzero fraction that it discarded. Integer-to-float conversion rounds to nearest, ties to even.

Top module: `fxf_convert`

## Requirements
- R1: With `to_float_i`=0 and `signed_i`=1, the result is the float value times 2^`fpos_i`, truncated toward zero, as a 32-bit two's-complement integer, provided that value lies in [-2^31, 2^31-1].
- R2: With `to_float_i`=0 and `signed_i`=0, a non-negative float value times 2^`fpos_i` is truncated toward zero and returned as an unsigned integer, provided it is below 2^32.
- R3: A finite or infinite value outside the selected integer range saturates and sets `range_err_o`. Signed results go to 0x7FFFFFFF for positive values and 0x80000000 for negative ones. Unsigned results go to 0xFFFFFFFF for positive values and 0 for negative ones. Infinities saturate by their sign.
- R4: A NaN operand (exponent field all ones and a nonzero mantissa) converted to integer gives 0 and sets `range_err_o`.
- R5: In unsigned float-to-integer mode, a negative operand gives 0. `range_err_o` is set only when the truncated magnitude is nonzero, so -0.0 and values in (-1,0) after scaling do not set it.
- R6: `frac_lost_o` is set when float-to-integer truncation discards a nonzero fraction and `range_err_o` is clear. The two bits are never both set.
- R7: With `to_float_i`=1, the operand is read as two's complement if `signed_i`=1 and as unsigned otherwise. It is divided by 2^`fpos_i` and rounded to nearest even single precision. An operand of 0 gives +0.0 (0x00000000).
- R8: Integer-to-float conversion leaves both `range_err_o` and `frac_lost_o` at 0.
- R9: `valid_o` is high exactly in the cycle after each `start_i` cycle. Result and status change only in that cycle and hold otherwise.
- R10: After reset, `valid_o`, `result_o`, `range_err_o` and `frac_lost_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to convert the operand |
| to_float_i | input | 1 | Direction: 0 float to integer, 1 integer to float |
| signed_i | input | 1 | Integer side is two's complement when 1, unsigned when 0 |
| fpos_i | input | 5 | Number of fraction bits on the integer side |
| operand_i | input | 32 | Operand, a float or an integer according to `to_float_i` |
| valid_o | output | 1 | Result valid, one cycle after `start_i` |
| result_o | output | 32 | Converted value |
| range_err_o | output | 1 | Float-to-integer value was out of range or NaN |
| frac_lost_o | output | 1 | Float-to-integer conversion discarded a nonzero fraction |

## Verification
The assertions assume that `start_i`, `to_float_i`, `signed_i`, `fpos_i` and `operand_i` carry known values in every cycle after reset, and that the controls and operand are meaningful during any cycle in which `start_i` is high. The bench meets this by giving every input a defined value from time zero and by changing inputs only on the falling clock edge. It holds them for the full start cycle and then drops `start_i`. The sweeps cover every exponent code, including zero, subnormals, infinities and NaN. They apply several mantissa shapes at binary points from 0 to 31. They also place round-to-nearest ties and sticky bits just below the 24-bit significand boundary.

// File: rtl/fxf_pkg.sv
package fxf_pkg;

   typedef enum logic {
      DIR_TO_INT   = 1'b0,
      DIR_TO_FLOAT = 1'b1
   } fxf_dir_e;

   typedef struct packed {
      logic range_err;
      logic frac_lost;
   } fxf_flags_t;

endpackage

// File: rtl/fxf_lzc.sv
module fxf_lzc #(
   parameter int W = 32
) (
   input  logic [W-1:0]         vec_i,
   output logic [$clog2(W)-1:0] cnt_o,
   output logic                 zero_o
);
   localparam int CW = $clog2(W);

   logic [W-1:0] first;

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         first[i] = vec_i[i] & ~seen;
         seen     = seen | vec_i[i];
      end
   end

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < W; i++) begin
         if (first[i]) cnt_o = cnt_o | CW'(W - 1 - i);
      end
   end

   assign zero_o = ~|vec_i;

endmodule

// File: rtl/fxf_f2i.sv
module fxf_f2i #(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int INT_W  = 32,
   parameter int FPOS_W = 5
) (
   input  logic [EXP_W+MAN_W:0] flt_i,
   input  logic                 signed_i,
   input  logic [FPOS_W-1:0]    fpos_i,
   output logic [INT_W-1:0]     res_o,
   output logic                 range_err_o,
   output logic                 frac_lost_o
);
   localparam int SIG_W   = MAN_W + 1;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int SH_W    = EXP_W + 3;
   localparam int MAX_LSH = INT_W - SIG_W;

   localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] U_MAX = {INT_W{1'b1}};

   logic                   sgn;
   logic [EXP_W-1:0]       ex;
   logic [EXP_W-1:0]       ex_eff;
   logic [MAN_W-1:0]       man;
   logic [SIG_W-1:0]       sig;
   logic signed [SH_W-1:0] sh;
   logic [SH_W-1:0]        rsh;
   logic [SH_W-1:0]        rsh_c;
   logic [INT_W-1:0]       mag;
   logic                   lost_bits;
   logic                   too_big;
   logic                   is_nan;
   logic                   is_inf;

   // field split and scale shift
   always_comb begin
      sgn    = flt_i[EXP_W+MAN_W];
      ex     = flt_i[EXP_W+MAN_W-1:MAN_W];
      man    = flt_i[MAN_W-1:0];
      is_nan = (&ex) & (|man);
      is_inf = (&ex) & ~(|man);
      sig    = {|ex, man};
      ex_eff = (ex == '0) ? EXP_W'(1) : ex;
      sh     = $signed(SH_W'(ex_eff)) + $signed(SH_W'(fpos_i))
             - $signed(SH_W'(BIAS + MAN_W));
      too_big = sh > $signed(SH_W'(MAX_LSH));
      rsh     = SH_W'(-sh);
      rsh_c   = (rsh > SH_W'(SIG_W)) ? SH_W'(SIG_W) : rsh;
      mag       = '0;
      lost_bits = 1'b0;
      if (!sh[SH_W-1]) begin
         mag = INT_W'(sig) << sh;
      end else begin
         mag       = INT_W'(sig >> rsh_c);
         lost_bits = |(sig << (SH_W'(SIG_W) - rsh_c));
      end
   end

   // range decision and saturation
   always_comb begin
      res_o       = '0;
      range_err_o = 1'b0;
      frac_lost_o = 1'b0;
      if (is_nan) begin
         range_err_o = 1'b1;
      end else if (is_inf || too_big) begin
         range_err_o = 1'b1;
         if (signed_i) res_o = sgn ? S_MIN : S_MAX;
         else          res_o = sgn ? '0 : U_MAX;
      end else if (signed_i) begin
         if (sgn) begin
            if (mag > S_MIN) begin
               res_o       = S_MIN;
               range_err_o = 1'b1;
            end else begin
               res_o       = INT_W'(0) - mag;
               frac_lost_o = lost_bits;
            end
         end else begin
            if (mag[INT_W-1]) begin
               res_o       = S_MAX;
               range_err_o = 1'b1;
            end else begin
               res_o       = mag;
               frac_lost_o = lost_bits;
            end
         end
      end else begin
         if (sgn) begin
            if (mag != '0) range_err_o = 1'b1;
            else           frac_lost_o = lost_bits;
         end else begin
            res_o       = mag;
            frac_lost_o = lost_bits;
         end
      end
   end

endmodule

// File: rtl/fxf_i2f.sv
module fxf_i2f #(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int INT_W  = 32,
   parameter int FPOS_W = 5
) (
   input  logic [INT_W-1:0]     int_i,
   input  logic                 signed_i,
   input  logic [FPOS_W-1:0]    fpos_i,
   output logic [EXP_W+MAN_W:0] flt_o
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int LZ_W = $clog2(INT_W);
   localparam int BODY_W = EXP_W + MAN_W;

   logic              neg;
   logic [INT_W-1:0]  mag;
   logic [INT_W-1:0]  norm;
   logic [LZ_W-1:0]   lz;
   logic              is_zero;
   logic [EXP_W-1:0]  exp_b;
   logic [MAN_W-1:0]  mant;
   logic              guard;
   logic              sticky;
   logic              inc;
   logic [BODY_W-1:0] body;

   assign neg = signed_i & int_i[INT_W-1];
   assign mag = neg ? (INT_W'(0) - int_i) : int_i;

   fxf_lzc #(.W(INT_W)) u_lzc (
      .vec_i  (mag),
      .cnt_o  (lz),
      .zero_o (is_zero)
   );

   always_comb begin
      norm   = mag << lz;
      exp_b  = EXP_W'(INT_W - 1 + BIAS) - EXP_W'(lz) - EXP_W'(fpos_i);
      mant   = norm[INT_W-2 -: MAN_W];
      guard  = norm[INT_W-2-MAN_W];
      sticky = |norm[INT_W-3-MAN_W:0];
      inc    = guard & (sticky | mant[0]);
      // a mantissa carry ripples into the exponent field
      body   = {exp_b, mant} + BODY_W'(inc);
      flt_o  = is_zero ? '0 : {neg, body};
   end

endmodule

// File: rtl/fxf_convert.sv
module fxf_convert #(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int INT_W  = 32,
   parameter int FPOS_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              to_float_i,
   input  logic              signed_i,
   input  logic [FPOS_W-1:0] fpos_i,
   input  logic [INT_W-1:0]  operand_i,
   output logic              valid_o,
   output logic [INT_W-1:0]  result_o,
   output logic              range_err_o,
   output logic              frac_lost_o
);
   import fxf_pkg::*;

   localparam int FLT_W = 1 + EXP_W + MAN_W;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

   // elaboration-time parameter checks
   generate
      if (FLT_W != INT_W) begin : g_bad_width
         $error("float and integer widths must match");
      end
      if (INT_W < MAN_W + 3) begin : g_bad_int
         $error("integer width too small for guard and sticky bits");
      end
      if ((1 << FPOS_W) > INT_W) begin : g_bad_fpos
         $error("binary point range exceeds integer width");
      end
      if (INT_W - 1 + BIAS >= (1 << EXP_W) - 1) begin : g_bad_exp_hi
         $error("exponent range too narrow for the largest integer");
      end
      if (BIAS - ((1 << FPOS_W) - 1) < 1) begin : g_bad_exp_lo
         $error("exponent range too narrow for the smallest fixed-point step");
      end
   endgenerate

   fxf_dir_e         dir;
   logic [INT_W-1:0] f2i_res;
   logic [INT_W-1:0] i2f_res;
   fxf_flags_t       f2i_flags;
   fxf_flags_t       next_flags;
   fxf_flags_t       flags_q;

   assign dir = fxf_dir_e'(to_float_i);

   fxf_f2i #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .FPOS_W(FPOS_W)
   ) u_f2i (
      .flt_i       (operand_i),
      .signed_i    (signed_i),
      .fpos_i      (fpos_i),
      .res_o       (f2i_res),
      .range_err_o (f2i_flags.range_err),
      .frac_lost_o (f2i_flags.frac_lost)
   );

   fxf_i2f #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .FPOS_W(FPOS_W)
   ) u_i2f (
      .int_i    (operand_i),
      .signed_i (signed_i),
      .fpos_i   (fpos_i),
      .flt_o    (i2f_res)
   );

   assign next_flags = (dir == DIR_TO_FLOAT) ? '0 : f2i_flags;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o  <= 1'b0;
         result_o <= '0;
         flags_q  <= '0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            result_o <= (dir == DIR_TO_FLOAT) ? i2f_res : f2i_res;
            flags_q  <= next_flags;
         end
      end
   end

   assign range_err_o = flags_q.range_err;
   assign frac_lost_o = flags_q.frac_lost;

endmodule

// File: rtl/fxf_convert_chk.sv
module fxf_convert_chk #(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int INT_W  = 32,
   parameter int FPOS_W = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic              to_float_i,
   input logic              signed_i,
   input logic [FPOS_W-1:0] fpos_i,
   input logic [INT_W-1:0]  operand_i,
   input logic              valid_o,
   input logic [INT_W-1:0]  result_o,
   input logic              range_err_o,
   input logic              frac_lost_o
);
   logic op_nan;
   assign op_nan = (&operand_i[EXP_W+MAN_W-1:MAN_W]) & (|operand_i[MAN_W-1:0]);

   // R9: valid follows start by one cycle
   p_valid_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> valid_o);

   // R9: no start means no valid and a held result
   p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> (!valid_o && $stable(result_o) && $stable(range_err_o)
                    && $stable(frac_lost_o)));

   // R4: NaN to integer gives zero with range error
   p_nan_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !to_float_i && op_nan) |=> (result_o == '0 && range_err_o));

   // R5: unsigned conversion of a negative float gives zero
   p_uns_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !to_float_i && !signed_i && operand_i[INT_W-1]) |=> (result_o == '0));

   // R6: range error and lost fraction are exclusive
   p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(range_err_o && frac_lost_o));

   // R7: zero integer gives positive zero
   p_zero_in_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && to_float_i && operand_i == '0) |=> (result_o == '0));

   // R7: sign of the float follows the integer interpretation
   p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && to_float_i) |=> (result_o[INT_W-1] == $past(signed_i && operand_i[INT_W-1])));

   // R8: integer-to-float raises no status
   p_i2f_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && to_float_i) |=> (!range_err_o && !frac_lost_o));

endmodule

bind fxf_convert fxf_convert_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .FPOS_W(FPOS_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .start_i     (start_i),
   .to_float_i  (to_float_i),
   .signed_i    (signed_i),
   .fpos_i      (fpos_i),
   .operand_i   (operand_i),
   .valid_o     (valid_o),
   .result_o    (result_o),
   .range_err_o (range_err_o),
   .frac_lost_o (frac_lost_o)
);

// File: tb/fxf_convert_tb.sv
`timescale 1ns/1ps
module fxf_convert_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        to_float = 1'b0;
   logic        sgn = 1'b0;
   logic [4:0]  fpos = '0;
   logic [31:0] operand = '0;
   logic        valid;
   logic [31:0] result;
   logic        range_err;
   logic        frac_lost;

   int  n_vec  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   always #2 clk = ~clk;

   fxf_convert u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .to_float_i  (to_float),
      .signed_i    (sgn),
      .fpos_i      (fpos),
      .operand_i   (operand),
      .valid_o     (valid),
      .result_o    (result),
      .range_err_o (range_err),
      .frac_lost_o (frac_lost)
   );

   task automatic check(input string tag, input logic [31:0] op,
                        input logic [31:0] exp_r, input logic exp_re, input logic exp_fl,
                        input logic exp_v);
      n_vec++;
      if (valid !== exp_v || result !== exp_r || range_err !== exp_re || frac_lost !== exp_fl) begin
         n_fail++;
         $display("FAIL %s op=%h dir=%b sgn=%b fpos=%0d: got v=%b r=%h re=%b fl=%b, expected v=%b r=%h re=%b fl=%b",
                  tag, op, to_float, sgn, fpos, valid, result, range_err, frac_lost,
                  exp_v, exp_r, exp_re, exp_fl);
      end
   endtask

   task automatic apply(input logic dir, input logic sg, input int f, input logic [31:0] op);
      @(negedge clk);
      to_float = dir;
      sgn      = sg;
      fpos     = f[4:0];
      operand  = op;
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   // expected float to integer, from real arithmetic
   task automatic exp_f2i(input logic [31:0] op, input bit sg, input int f,
                          output logic [31:0] r, output bit re, output bit fl, output string tag);
      int   e;
      int   ev;
      int   m;
      bit   s;
      real  v;
      real  t;
      s = op[31];
      e = int'(op[30:23]);
      m = int'(op[22:0]);
      r = '0; re = 0; fl = 0;
      if (e == 255) begin
         re = 1;
         if (m != 0) begin
            tag = "R4";
         end else begin
            tag = "R3";
            if (sg) r = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else    r = s ? 32'h0 : 32'hFFFF_FFFF;
         end
         return;
      end
      ev = (e == 0) ? 1 : e;
      if (e != 0) m = m + (1 << 23);
      v = real'(m) * (2.0 ** (ev - 150 + f));
      t = $floor(v);
      if (sg) begin
         if (s && t > 2147483648.0) begin
            re = 1; r = 32'h8000_0000; tag = "R3";
         end else if (!s && t > 2147483647.0) begin
            re = 1; r = 32'h7FFF_FFFF; tag = "R3";
         end else begin
            r   = s ? 32'(-longint'(t)) : 32'(longint'(t));
            fl  = (t != v);
            tag = fl ? "R6" : "R1";
         end
      end else begin
         if (s) begin
            tag = "R5";
            if (t != 0.0) re = 1;
            else          fl = (t != v);
         end else if (t > 4294967295.0) begin
            re = 1; r = 32'hFFFF_FFFF; tag = "R3";
         end else begin
            r   = 32'(longint'(t));
            fl  = (t != v);
            tag = fl ? "R6" : "R2";
         end
      end
   endtask

   // expected integer to float, from explicit round-half-even on the magnitude
   task automatic exp_i2f(input logic [31:0] op, input bit sg, input int f, output logic [31:0] r);
      bit          neg;
      logic [63:0] mag;
      logic [63:0] q;
      logic [63:0] rem;
      logic [63:0] half;
      int          p;
      int          sh;
      int          ex;
      neg = sg && op[31];
      mag = neg ? (64'h1_0000_0000 - {32'h0, op}) : {32'h0, op};
      if (mag == 0) begin
         r = '0;
         return;
      end
      p = 0;
      for (int i = 0; i < 33; i++) if (mag[i]) p = i;
      if (p <= 23) begin
         q = mag << (23 - p);
      end else begin
         sh   = p - 23;
         q    = mag >> sh;
         rem  = mag & ((64'd1 << sh) - 64'd1);
         half = 64'd1 << (sh - 1);
         if (rem > half || (rem == half && q[0])) q = q + 64'd1;
         if (q == (64'd1 << 24)) begin
            q = q >> 1;
            p = p + 1;
         end
      end
      ex = p - f + 127;
      r  = {neg, ex[7:0], q[22:0]};
   endtask

   task automatic run_f2i(input bit sg, input int f, input logic [31:0] op);
      logic [31:0] r;
      bit          re;
      bit          fl;
      string       tag;
      exp_f2i(op, sg, f, r, re, fl, tag);
      apply(1'b0, sg, f, op);
      check(tag, op, r, re, fl, 1'b1);
   endtask

   task automatic run_i2f(input bit sg, input int f, input logic [31:0] op);
      logic [31:0] r;
      exp_i2f(op, sg, f, r);
      apply(1'b1, sg, f, op);
      check("R7/R8", op, r, 1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      int fset[5];
      logic [22:0] mpat[5];
      logic [63:0] ipat[6];
      logic [31:0] held;
      fset = '{0, 1, 8, 19, 31};
      mpat = '{23'h000000, 23'h000001, 23'h400000, 23'h7FFFFF, 23'h2AAAAB};

      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10", 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);

      // R1..R6: float to integer sweep over every exponent code
      for (int sg = 0; sg < 2; sg++)
         foreach (fset[fi])
            for (int s = 0; s < 2; s++)
               for (int e = 0; e < 256; e++)
                  foreach (mpat[mi])
                     run_f2i(sg[0], fset[fi], {s[0], e[7:0], mpat[mi]});

      // R7, R8: integer to float across magnitudes, ties and sticky bits
      for (int sg = 0; sg < 2; sg++)
         foreach (fset[fi])
            for (int p = 0; p < 32; p++) begin
               ipat[0] = 64'd1 << p;
               ipat[1] = (64'd2 << p) - 64'd1;
               ipat[2] = ipat[0] | ((p >= 24) ? (64'd1 << (p - 24)) : 64'd0);
               ipat[3] = ipat[2] | ((p >= 23) ? (64'd1 << (p - 23)) : 64'd0);
               ipat[4] = ipat[2] | ((p >= 25) ? 64'd1 : 64'd0);
               ipat[5] = ipat[0] | (64'h5A5A_5A5A >> (31 - p));
               foreach (ipat[k]) run_i2f(sg[0], fset[fi], ipat[k][31:0]);
            end
      foreach (fset[fi]) begin
         run_i2f(1'b1, fset[fi], 32'h0);
         run_i2f(1'b0, fset[fi], 32'h0);
         run_i2f(1'b1, fset[fi], 32'h8000_0000);
         run_i2f(1'b0, fset[fi], 32'hFFFF_FFFF);
         run_i2f(1'b1, fset[fi], 32'hFFFF_FFFF);
      end

      // R9: outputs hold while idle, with inputs changing underneath
      run_f2i(1'b1, 0, 32'h4049_0FDB);
      held = result;
      @(negedge clk);
      to_float = 1'b1;
      operand  = 32'h1234_5678;
      @(negedge clk);
      check("R9", 32'h4049_0FDB, held, 1'b0, 1'b1, 1'b0);
      run_i2f(1'b0, 4, 32'h0000_0030);
      held = result;
      @(negedge clk);
      check("R9", 32'h0000_0030, held, 1'b0, 1'b0, 1'b0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule